// File: doc/BRIEF.md
# Sampled Shadow-Tag Cache Monitor

This block observes last-level cache accesses, each carrying an application ID. For each application it estimates how many misses that application would take if it ran alone on a large cache and if it ran alone on a small one. It holds tag-only shadow directories, one per application per modelled capacity. Only every 32nd set of each capacity is mirrored. A lookup gives only hit or miss. Because each application has its own directories, the estimates hold even while the applications share the real cache.

Software reads per-application counters through a small register port: sampled accesses and misses for each capacity, plus retired instructions. It divides misses by instructions to get misses per instruction. A control write clears the counters, invalidates every shadow entry, or does both. Software uses it to start a fresh training interval.

Top module: `shadow_monitor`

## Requirements
- R1: Lines are 64 bytes and both capacities are 16-way. The large directory has 4096 sets, indexed by address bits [17:6], with bits [31:18] as the tag. The small directory has 512 sets, indexed by bits [14:6], with bits [31:15] as the tag.
- R2: An access is looked up in a directory only when its set index for that capacity has its low 5 bits at zero. Any other access changes neither that directory's counters nor its state.
- R3: Each application has private directories. Accesses by one application never make another application hit or miss.
- R4: Each sampled set uses true LRU. A miss fills the least recently used way, and every hit or fill makes the touched way most recently used.
- R5: Every accepted access is looked up in the large and the small directory of its application in the same cycle. The two directories keep independent state, so one line can hit in the large directory and miss in the small one.
- R6: Per application there are five unsigned counters that saturate at all ones: large accesses, large misses, small accesses, small misses, and instructions. The instruction counter adds that application's retire count, which is 4 bits per application packed from application 0 upward, on every cycle.
- R7: A control write with bit 0 set clears all counters. Clear takes priority over any count arriving in the same cycle.
- R8: A control write with bit 1 set invalidates all shadow entries, so the next access to any line misses. An access offered in the same cycle as any control write is ignored.
- R9: Register address = application*8 + index. Index 0 is large accesses, 1 is large misses, 2 is small accesses, 3 is small misses and 4 is instructions. All other addresses read zero. Read data is registered and shows the counter values from before the clock edge that follows the address.
- R10: One access is accepted per cycle. An access in the cycle right after another access to the same set sees the state that the first access left.
- R11: After reset all counters read zero and all shadow entries are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_addr_i | input | ADDR_W | Physical byte address of the access |
| acc_app_i | input | APP_W | Application ID of the access |
| retire_i | input | NUM_APPS*RET_W | Instructions retired this cycle, per application |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 2 | Bit 0 clears counters, bit 1 invalidates shadow entries |
| rd_addr_i | input | APP_W+3 | Counter register address |
| rd_data_o | output | CNT_W | Registered counter read data |

## Verification
A repeated access to one line tells a hit from a miss and checks that the update reaches the next cycle. Replaying the same address under the other application ID checks isolation between applications. Seventeen lines that share one small set but spread over eight large sets separate the two capacities: the first line still hits in the large directory but has been evicted from the small one. A fill-touch-evict pattern in one small set checks that eviction follows recency and not fill order. Random traffic from a small pool of addresses, mixed with control writes, is compared every cycle against a queue-based model, and long retire bursts drive the instruction counter into saturation.

// File: rtl/shadow_mon_pkg.sv
package shadow_mon_pkg;
  typedef enum logic [2:0] {
    REG_LG_ACC  = 3'd0,
    REG_LG_MISS = 3'd1,
    REG_SM_ACC  = 3'd2,
    REG_SM_MISS = 3'd3,
    REG_INSTR   = 3'd4
  } reg_idx_e;
  localparam int NUM_REGS     = 5;
  localparam int CTRL_CLR_BIT = 0;
  localparam int CTRL_INV_BIT = 1;
endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int CNT_W = 32,
  parameter int INC_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum;

  assign sum   = {1'b0, cnt_q} + {{(CNT_W+1-INC_W){1'b0}}, inc_i};
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (inc_i != '0) cnt_q <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
  end

  assert_cnt_mono_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> cnt_q >= $past(cnt_q));
  assert_cnt_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/shadow_dir.sv
module shadow_dir #(
  parameter int BLK_W    = 26,
  parameter int SET_W    = 12,
  parameter int SAMPLE_W = 5,
  parameter int WAYS     = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inval_i,
  input  logic             req_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic             lookup_o,
  output logic             hit_o
);
  localparam int TAG_W = BLK_W - SET_W;
  localparam int IDX_W = SET_W - SAMPLE_W;
  localparam int NS    = 1 << IDX_W;
  localparam int AGE_W = $clog2(WAYS);

  function automatic logic [WAYS*AGE_W-1:0] init_ages();
    logic [WAYS*AGE_W-1:0] r;
    for (int w = 0; w < WAYS; w++) r[w*AGE_W +: AGE_W] = AGE_W'(w);
    return r;
  endfunction
  localparam logic [WAYS*AGE_W-1:0] AGE_INIT = init_ages();

  logic [WAYS*TAG_W-1:0] tag_q [NS];
  logic [WAYS*AGE_W-1:0] age_q [NS];
  logic [WAYS-1:0]       vld_q [NS];

  logic [SET_W-1:0]      set_idx;
  logic [IDX_W-1:0]      sidx;
  logic [TAG_W-1:0]      tag;
  logic                  sampled;
  logic [WAYS-1:0]       hit_vec;
  logic [AGE_W-1:0]      hit_way, vic_way, way_sel, touch_age;
  logic [WAYS*AGE_W-1:0] row_age, new_age;

  assign set_idx  = blk_i[SET_W-1:0];
  assign tag      = blk_i[BLK_W-1:SET_W];
  assign sidx     = set_idx[SET_W-1:SAMPLE_W];
  assign sampled  = (set_idx[SAMPLE_W-1:0] == '0);
  assign row_age  = age_q[sidx];
  assign lookup_o = req_i & sampled & ~inval_i;
  assign hit_o    = lookup_o & (|hit_vec);

  always_comb begin
    hit_way = '0;
    vic_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = vld_q[sidx][w] && (tag_q[sidx][w*TAG_W +: TAG_W] == tag);
      if (hit_vec[w]) hit_way = AGE_W'(w);
      if (row_age[w*AGE_W +: AGE_W] == AGE_W'(WAYS-1)) vic_way = AGE_W'(w);
    end
    way_sel   = (|hit_vec) ? hit_way : vic_way;
    touch_age = row_age[way_sel*AGE_W +: AGE_W];
    for (int w = 0; w < WAYS; w++) begin
      if (AGE_W'(w) == way_sel)
        new_age[w*AGE_W +: AGE_W] = '0;
      else if (row_age[w*AGE_W +: AGE_W] < touch_age)
        new_age[w*AGE_W +: AGE_W] = row_age[w*AGE_W +: AGE_W] + 1'b1;
      else
        new_age[w*AGE_W +: AGE_W] = row_age[w*AGE_W +: AGE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || inval_i) begin
      for (int s = 0; s < NS; s++) begin
        vld_q[s] <= '0;
        age_q[s] <= AGE_INIT;
      end
    end else if (lookup_o) begin
      vld_q[sidx][way_sel] <= 1'b1;
      age_q[sidx]          <= new_age;
    end
  end

  // invalid ways stay oldest, so the LRU victim also covers empty ways
  always_ff @(posedge clk_i) begin
    if (lookup_o && !(|hit_vec)) tag_q[sidx][way_sel*TAG_W +: TAG_W] <= tag;
  end

  logic             chk_q;
  logic [IDX_W-1:0] chk_idx_q;
  logic [AGE_W-1:0] chk_way_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_q     <= 1'b0;
      chk_idx_q <= '0;
      chk_way_q <= '0;
    end else begin
      chk_q     <= lookup_o;
      chk_idx_q <= sidx;
      chk_way_q <= way_sel;
    end
  end

  assert_fill_mru_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_q |-> (vld_q[chk_idx_q][chk_way_q] && age_q[chk_idx_q][chk_way_q*AGE_W +: AGE_W] == '0));
  assert_unique_tag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_o |-> $onehot0(hit_vec));
  assert_inval_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> !hit_o);
endmodule

// File: rtl/shadow_monitor.sv
module shadow_monitor
  import shadow_mon_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_APPS = 2,
  parameter int WAYS     = 16,
  parameter int LINE_W   = 6,
  parameter int LG_SET_W = 12,
  parameter int SM_SET_W = 9,
  parameter int SAMPLE_W = 5,
  parameter int CNT_W    = 32,
  parameter int RET_W    = 4,
  localparam int APP_W   = (NUM_APPS > 1) ? $clog2(NUM_APPS) : 1,
  localparam int RA_W    = APP_W + 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      acc_valid_i,
  input  logic [ADDR_W-1:0]         acc_addr_i,
  input  logic [APP_W-1:0]          acc_app_i,
  input  logic [NUM_APPS*RET_W-1:0] retire_i,
  input  logic                      ctrl_we_i,
  input  logic [1:0]                ctrl_wdata_i,
  input  logic [RA_W-1:0]           rd_addr_i,
  output logic [CNT_W-1:0]          rd_data_o
);
  localparam int BLK_W = ADDR_W - LINE_W;

  logic             clr, inv;
  logic [BLK_W-1:0] blk;
  logic             unused_offset;
  logic [CNT_W-1:0] cnt [NUM_APPS][NUM_REGS];

  assign clr           = ctrl_we_i & ctrl_wdata_i[CTRL_CLR_BIT];
  assign inv           = ctrl_we_i & ctrl_wdata_i[CTRL_INV_BIT];
  assign blk           = acc_addr_i[ADDR_W-1:LINE_W];
  assign unused_offset = ^acc_addr_i[LINE_W-1:0];

  for (genvar a = 0; a < NUM_APPS; a++) begin : g_app
    logic req;
    assign req = acc_valid_i & ~ctrl_we_i & (acc_app_i == APP_W'(a));

    for (genvar c = 0; c < 2; c++) begin : g_cfg
      logic look, hit, miss;
      assign miss = look & ~hit;

      shadow_dir #(
        .BLK_W   (BLK_W),
        .SET_W   ((c == 0) ? LG_SET_W : SM_SET_W),
        .SAMPLE_W(SAMPLE_W),
        .WAYS    (WAYS)
      ) u_dir (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .inval_i (inv),
        .req_i   (req),
        .blk_i   (blk),
        .lookup_o(look),
        .hit_o   (hit)
      );

      sat_counter #(.CNT_W(CNT_W), .INC_W(1)) u_acc (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .inc_i(look), .cnt_o(cnt[a][2*c]));
      sat_counter #(.CNT_W(CNT_W), .INC_W(1)) u_miss (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .inc_i(miss), .cnt_o(cnt[a][2*c+1]));
    end

    sat_counter #(.CNT_W(CNT_W), .INC_W(RET_W)) u_instr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr),
      .inc_i (retire_i[a*RET_W +: RET_W]),
      .cnt_o (cnt[a][REG_INSTR])
    );
  end

  logic [APP_W-1:0] rd_app;
  logic [2:0]       rd_idx;
  logic [CNT_W-1:0] rd_sel;
  assign rd_app = rd_addr_i[RA_W-1:3];
  assign rd_idx = rd_addr_i[2:0];

  always_comb begin
    rd_sel = '0;
    for (int a = 0; a < NUM_APPS; a++)
      for (int r = 0; r < NUM_REGS; r++)
        if (rd_app == APP_W'(a) && rd_idx == 3'(r)) rd_sel = cnt[a][r];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else         rd_data_o <= rd_sel;
  end

  assert_rd_reset_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> rd_data_o == '0);
  assert_clr_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !inv) |=> ##1 rd_data_o == '0);
endmodule

// File: tb/tb_shadow_monitor.sv
`timescale 1ns/1ps
module tb_shadow_monitor;
  localparam int CNT_W   = 12;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_valid_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic [0:0]  acc_app_i = '0;
  logic [7:0]  retire_i = '0;
  logic        ctrl_we_i = 1'b0;
  logic [1:0]  ctrl_wdata_i = '0;
  logic [3:0]  rd_addr_i = '0;
  logic [CNT_W-1:0] rd_data_o;

  shadow_monitor #(.CNT_W(CNT_W)) dut (.*);

  always #2.5 clk_i = ~clk_i;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  int mc [2][5];
  int unsigned tq [2][2][4096][$];
  int exp_rd = 0;

  function automatic int m_read(int a);
    int app = a >> 3, idx = a & 7;
    if (app < 2 && idx < 5) return mc[app][idx];
    return 0;
  endfunction

  function automatic int sat_add(int v, int d);
    return (v + d > CNT_MAX) ? CNT_MAX : v + d;
  endfunction

  task automatic m_step();
    if (ctrl_we_i) begin
      if (ctrl_wdata_i[0]) foreach (mc[a, r]) mc[a][r] = 0;
      if (ctrl_wdata_i[1])
        for (int a = 0; a < 2; a++) for (int c = 0; c < 2; c++)
          for (int s = 0; s < 4096; s++) tq[a][c][s].delete();
    end else if (acc_valid_i) begin
      int app = acc_app_i;
      for (int c = 0; c < 2; c++) begin
        int sbits = (c == 0) ? 12 : 9;
        int set = (acc_addr_i >> 6) & ((1 << sbits) - 1);
        int unsigned tg = acc_addr_i >> (6 + sbits);
        if ((set & 31) == 0) begin
          int pos = -1;
          mc[app][2*c] = sat_add(mc[app][2*c], 1);
          for (int i = 0; i < tq[app][c][set].size(); i++)
            if (tq[app][c][set][i] == tg) pos = i;
          if (pos >= 0) tq[app][c][set].delete(pos);
          else begin
            mc[app][2*c+1] = sat_add(mc[app][2*c+1], 1);
            if (tq[app][c][set].size() == 16) void'(tq[app][c][set].pop_back());
          end
          tq[app][c][set].push_front(tg);
        end
      end
    end
    if (!(ctrl_we_i && ctrl_wdata_i[0]))
      for (int a = 0; a < 2; a++) mc[a][4] = sat_add(mc[a][4], int'(retire_i[a*4 +: 4]));
  endtask

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      foreach (mc[a, r]) mc[a][r] = 0;
      exp_rd = 0;
    end else begin
      exp_rd = m_read(int'(rd_addr_i));
      m_step();
    end
  end

  always @(negedge clk_i) if (rst_ni && !done) chk("R9 per-cycle", int'(rd_data_o), exp_rd);

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] mk(int set, int tag);
    return (32'(tag) << 18) | (32'(set) << 6);
  endfunction

  task automatic idle();
    @(negedge clk_i);
    acc_valid_i = 0; ctrl_we_i = 0; retire_i = '0;
  endtask

  task automatic acc(int app, logic [31:0] addr);
    @(negedge clk_i);
    acc_valid_i = 1; acc_app_i = 1'(app); acc_addr_i = addr;
    ctrl_we_i = 0; retire_i = '0;
  endtask

  task automatic rd_check(int a, int exp, string req);
    @(negedge clk_i);
    acc_valid_i = 0; ctrl_we_i = 0; retire_i = '0; rd_addr_i = 4'(a);
    @(negedge clk_i);
    chk(req, int'(rd_data_o), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R11: reset state
    for (int a = 0; a < 16; a++) rd_check(a, 0, "R11 reset");

    // R2: unsampled set
    acc(0, mk(1, 5));
    for (int r = 0; r < 4; r++) rd_check(r, 0, "R2 unsampled");

    // R1/R10: same line back-to-back -> miss then hit
    acc(0, mk(0, 1)); acc(0, mk(0, 1));
    rd_check(0, 2, "R1 lg acc"); rd_check(1, 1, "R10 lg miss");
    rd_check(2, 2, "R1 sm acc"); rd_check(3, 1, "R10 sm miss");

    // R3: other application misses on same line
    acc(1, mk(0, 1));
    rd_check(9, 1, "R3 app1 lg miss"); rd_check(1, 1, "R3 app0 unchanged");

    // R5: 17 lines in one small set, spread over 8 large sets
    for (int i = 0; i < 17; i++) acc(1, mk((i % 8) * 512, 10 + i));
    acc(1, mk(0, 10));
    rd_check(8, 19, "R5 lg acc"); rd_check(9, 18, "R5 lg hit kept");
    rd_check(10, 19, "R5 sm acc"); rd_check(11, 19, "R5 sm evicted");

    // R4: LRU in small set 32 of app0
    for (int j = 0; j < 16; j++) acc(0, mk(32 + (j % 8) * 512, 100 + j));
    acc(0, mk(32, 100));
    acc(0, mk(32, 116));
    acc(0, mk(32, 100));
    acc(0, mk(32 + 512, 101));
    rd_check(2, 22, "R4 sm acc"); rd_check(3, 19, "R4 sm miss");
    rd_check(0, 22, "R4 lg acc"); rd_check(1, 18, "R4 lg miss");

    // R6: instruction counting and saturation
    for (int k = 0; k < 300; k++) begin
      @(negedge clk_i);
      acc_valid_i = 0; ctrl_we_i = 0; retire_i = {4'd3, 4'd15};
    end
    rd_check(4, CNT_MAX, "R6 saturate"); rd_check(12, 900, "R6 instr");

    // R8: invalidate, with an access in the same cycle ignored
    @(negedge clk_i);
    ctrl_we_i = 1; ctrl_wdata_i = 2'b10; acc_valid_i = 1; acc_app_i = 0; acc_addr_i = mk(0, 1);
    idle();
    rd_check(0, 22, "R8 access ignored");
    acc(0, mk(0, 1));
    rd_check(0, 23, "R8 lg acc"); rd_check(1, 19, "R8 miss after inval");

    // R7: clear
    @(negedge clk_i);
    ctrl_we_i = 1; ctrl_wdata_i = 2'b01; acc_valid_i = 0; retire_i = 8'hFF;
    idle();
    for (int a = 0; a < 13; a++) rd_check(a, 0, "R7 clear");

    // random traffic against the model
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk_i);
      acc_valid_i = ($urandom_range(0, 3) != 0);
      acc_app_i   = 1'($urandom_range(0, 1));
      acc_addr_i  = mk($urandom_range(0, 3) * 512 + $urandom_range(0, 1) * 32 + $urandom_range(0, 1),
                       $urandom_range(0, 20)) | 32'($urandom_range(0, 63));
      retire_i    = 8'($urandom);
      ctrl_we_i   = ($urandom_range(0, 499) == 0);
      ctrl_wdata_i = 2'($urandom_range(1, 3));
      rd_addr_i   = 4'($urandom_range(0, 15));
    end
    idle();
    idle();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule